// File: doc/BRIEF.md
# Soft-Ramp Digital Attenuator

This block is the digital volume stage that sits after the converter for a single audio channel. Software writes a 7-bit attenuation code through a byte-wide write port. The block turns that code into a linear gain target on a pseudo-logarithmic curve. Incoming signed 24-bit samples are multiplied by the current gain, normalised to a full scale of 8031, rounded and saturated.

The gain never jumps. Each accepted sample moves the current gain one unit toward the target, so a level change walks through the fine linear scale and produces no audible step. A code written in the middle of a ramp changes the destination at once, and the ramp carries on from wherever the gain stands at that moment. The write port shares its byte with an analog gain field. A byte with bit 7 set belongs to that field, and this block drops it.

Top module: `soft_ramp_atten`

## Requirements
- R1: After synchronous reset the output valid is low, the output data is zero, the stored code is 00h and the current gain is 0, so samples sent before any write come out as zero.
- R2: A write with `code_we` high and `code_wdata[7]` = 0 stores `code_wdata[6:0]` as the new target code from the next cycle. A write with `code_wdata[7]` = 1 leaves the stored code and all later outputs unchanged.
- R3: Code 00h maps to gain 0 (mute). Any other code c, with e = c[6:4] and m = c[3:0], maps to floor(((16+m) << e) * 8031 / 3968). This puts 7Fh at 8031, which is unity, and the curve strictly increases with the code.
- R4: On each cycle with `in_valid` high, the current gain moves by exactly one toward the target gain and stops exactly on it. On cycles without `in_valid` the gain does not move.
- R5: A new code written during a ramp retargets immediately. The ramp continues from the current gain and does not restart from either end.
- R6: Each output equals x*g/8031 rounded half away from zero and saturated to the 24-bit signed range. Here x is the input sample and g is the current gain in the cycle that sample is accepted, taken before that sample's step.
- R7: `out_valid` is high exactly two cycles after each `in_valid` cycle and at no other time. Results come out in input order.
- R8: At gain 8031 every sample, including the most positive and most negative values, passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| code_we | input | 1 | Write strobe for the code byte |
| code_wdata | input | 8 | Code byte; bit 7 selects the analog field (ignored here), bits 6:0 the attenuation code |
| in_valid | input | 1 | Input sample strobe, also the ramp step enable |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe, two cycles after `in_valid` |
| out_data | output | 24 | Signed scaled sample |

## Verification
The bench feeds a constant sample of 8031 through full ramps. At that value each output equals the gain in use, so a design that skips a step, overshoots the target, or steps on idle cycles shows a wrong value at once. It retargets in the middle of a ramp and leaves idle gaps between samples. A design that restarts the ramp from an end, or lets the gain drift without a sample, then gives the wrong sequence. It writes a byte with bit 7 set after the gain has settled, which catches a design that decodes all eight bits and mutes or shifts the gain. Last, it probes several codes on the curve, including the boundaries 01h, 0Fh, 10h and 7Eh, and sends small odd and negative samples. A wrong exponent split, truncation instead of rounding, or asymmetric handling of negative products then gives an output that is off by one or more.

// File: rtl/dvol_pkg.sv
// Package: shared constants for the soft-ramp attenuator.
// Assumes the gain scale is 0..FULL_SCALE with FULL_SCALE as unity.
package dvol_pkg;
    localparam int unsigned SAMPLE_W   = 24;
    localparam int unsigned CODE_W     = 7;
    localparam int unsigned GAIN_W     = 13;
    localparam int unsigned FULL_SCALE = 8031;
endpackage

// File: rtl/dvol_target.sv
// dvol_target: holds the attenuation code and maps it to a linear gain.
// The code splits into a 3-bit exponent and a mantissa; the curve
// (16+m)<<e is rescaled so the top code lands on FULL_SCALE.
// Assumes bit CODE_W of the write byte selects another field, so such
// writes are dropped.
module dvol_target #(
    parameter int unsigned CODE_W     = dvol_pkg::CODE_W,
    parameter int unsigned GAIN_W     = dvol_pkg::GAIN_W,
    parameter int unsigned FULL_SCALE = dvol_pkg::FULL_SCALE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W:0]   wr_data,
    output logic [GAIN_W-1:0] target_gain
);
    localparam int unsigned EXP_W   = 3;
    localparam int unsigned MANT_W  = CODE_W - EXP_W;
    localparam int unsigned SHIFT_W = MANT_W + 1 + (1 << EXP_W) - 1;
    localparam int unsigned PROD_W  = SHIFT_W + GAIN_W;
    localparam int unsigned SPAN    = ((2 << MANT_W) - 1) << ((1 << EXP_W) - 1);

    logic [CODE_W-1:0]  code_q;
    logic [EXP_W-1:0]   exp_c;
    logic [SHIFT_W-1:0] shifted_c;
    logic [PROD_W-1:0]  prod_c;
    logic [PROD_W-1:0]  quot_c;

    // Store the code only for writes aimed at this field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (wr_en && !wr_data[CODE_W]) begin
            code_q <= wr_data[CODE_W-1:0];
        end
    end

    // Pseudo-log curve: implicit-one mantissa shifted by the exponent.
    always_comb begin
        exp_c       = code_q[CODE_W-1 -: EXP_W];
        shifted_c   = SHIFT_W'({1'b1, code_q[MANT_W-1:0]}) << exp_c;
        prod_c      = PROD_W'(shifted_c) * PROD_W'(FULL_SCALE);
        quot_c      = prod_c / PROD_W'(SPAN);
        target_gain = (code_q == '0) ? '0 : GAIN_W'(quot_c);
    end

    assert_high_bit_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CODE_W]) |=> $stable(code_q));

    assert_target_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        target_gain <= GAIN_W'(FULL_SCALE));
endmodule

// File: rtl/dvol_ramp.sv
// dvol_ramp: current gain register that walks one unit toward the target
// on every step enable. Assumes the target never exceeds FULL_SCALE.
module dvol_ramp #(
    parameter int unsigned GAIN_W = dvol_pkg::GAIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [GAIN_W-1:0] target_gain,
    output logic [GAIN_W-1:0] gain_q
);
    // Single-unit approach toward the target; no move without a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
        end else if (step_en) begin
            if (gain_q < target_gain) begin
                gain_q <= gain_q + 1'b1;
            end else if (gain_q > target_gain) begin
                gain_q <= gain_q - 1'b1;
            end
        end
    end

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(gain_q));

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && gain_q < target_gain) |=> gain_q == $past(gain_q) + 1'b1);

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && gain_q > target_gain) |=> gain_q == $past(gain_q) - 1'b1);

    assert_stop_on_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && gain_q == target_gain) |=> $stable(gain_q));
endmodule

// File: rtl/dvol_scale.sv
// dvol_scale: two-stage multiply and normalise. Stage 1 registers
// sample*gain; stage 2 divides by FULL_SCALE with round-half-away
// rounding and saturates to the sample width.
// Assumes gain is unsigned and at most FULL_SCALE.
module dvol_scale #(
    parameter int unsigned SAMPLE_W   = dvol_pkg::SAMPLE_W,
    parameter int unsigned GAIN_W     = dvol_pkg::GAIN_W,
    parameter int unsigned FULL_SCALE = dvol_pkg::FULL_SCALE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic [GAIN_W-1:0]   gain,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);
    localparam int unsigned PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam int unsigned ACC_W  = PROD_W + 1;
    localparam logic signed [ACC_W-1:0] DIVISOR = ACC_W'(FULL_SCALE);
    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(FULL_SCALE / 2);
    localparam logic signed [ACC_W-1:0] SAT_HI  = ACC_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO  = -SAT_HI - ACC_W'(1);

    logic signed [PROD_W-1:0] prod_q;
    logic                     v1_q;
    logic signed [ACC_W-1:0]  rnd_c;
    logic signed [ACC_W-1:0]  quot_c;
    logic [SAMPLE_W-1:0]      sat_c;

    // Stage 1: capture the product of the accepted sample and the gain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                prod_q <= $signed(in_data) * $signed({1'b0, gain});
            end
        end
    end

    // Round half away from zero, divide toward zero, then clamp.
    always_comb begin
        rnd_c  = prod_q[PROD_W-1] ? (ACC_W'(prod_q) - HALF) : (ACC_W'(prod_q) + HALF);
        quot_c = rnd_c / DIVISOR;
        if (quot_c > SAT_HI) begin
            sat_c = SAMPLE_W'(SAT_HI);
        end else if (quot_c < SAT_LO) begin
            sat_c = SAMPLE_W'(SAT_LO);
        end else begin
            sat_c = SAMPLE_W'(quot_c);
        end
    end

    // Stage 2: register the normalised result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) begin
                out_data <= sat_c;
            end
        end
    end
endmodule

// File: rtl/soft_ramp_atten.sv
// soft_ramp_atten: one-channel digital volume with soft gain ramps.
// Code writes set a target gain; each valid sample steps the gain by one
// toward it and is scaled by the gain held before that step.
// Assumes at most one sample per cycle; writes and samples may overlap.
module soft_ramp_atten #(
    parameter int unsigned SAMPLE_W   = dvol_pkg::SAMPLE_W,
    parameter int unsigned CODE_W     = dvol_pkg::CODE_W,
    parameter int unsigned GAIN_W     = dvol_pkg::GAIN_W,
    parameter int unsigned FULL_SCALE = dvol_pkg::FULL_SCALE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                code_we,
    input  logic [CODE_W:0]     code_wdata,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);
    logic [GAIN_W-1:0] target_gain;
    logic [GAIN_W-1:0] cur_gain;

    dvol_target #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .FULL_SCALE(FULL_SCALE)) u_target (
        .clk(clk), .rst_n(rst_n), .wr_en(code_we), .wr_data(code_wdata),
        .target_gain(target_gain)
    );

    dvol_ramp #(.GAIN_W(GAIN_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .step_en(in_valid),
        .target_gain(target_gain), .gain_q(cur_gain)
    );

    dvol_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FULL_SCALE(FULL_SCALE)) u_scale (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .gain(cur_gain), .out_valid(out_valid), .out_data(out_data)
    );

    assert_latency_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    assert_mute_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_gain, 2) == '0) |-> out_data == '0);

    assert_unity_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cur_gain, 2) == GAIN_W'(FULL_SCALE)) |-> out_data == $past(in_data, 2));
endmodule

// File: tb/sim_soft_ramp_atten.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each output from a model of the
// requirements and queues it; a monitor pops and compares on out_valid.
module sim_soft_ramp_atten;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_we = 1'b0;
    logic [7:0]  code_wdata = '0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int    n_tests = 0;
    int    n_fail = 0;
    longint cyc = 0;
    bit    done = 1'b0;

    typedef struct {
        int     data;
        longint cyc;
        string  tag;
    } exp_t;
    exp_t sb[$];

    int m_code = 0;
    int m_gain = 0;

    soft_ramp_atten u0 (
        .clk(clk), .rst_n(rst_n), .code_we(code_we), .code_wdata(code_wdata),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // R3 curve from the requirement text.
    function automatic int tgain(int c);
        int e;
        int m;
        if (c == 0) return 0;
        e = (c >> 4) & 7;
        m = c & 15;
        return int'((longint'((16 + m) << e) * 8031) / 3968);
    endfunction

    // R6 rounding: half away from zero, then clamp.
    function automatic int scale(int x, int g);
        longint p;
        longint a;
        longint q;
        p = longint'(x) * g;
        a = (p < 0) ? -p : p;
        q = (a + 4015) / 8031;
        if (p < 0) q = -q;
        if (q > 8388607) q = 8388607;
        if (q < -8388608) q = -8388608;
        return int'(q);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Driver: called at a falling edge, leaves at the next falling edge.
    task automatic send(int x, string tag);
        exp_t e;
        e.data = scale(x, m_gain);
        e.cyc  = cyc + 2;
        e.tag  = tag;
        sb.push_back(e);
        if (m_gain < tgain(m_code)) m_gain++;
        else if (m_gain > tgain(m_code)) m_gain--;
        in_valid = 1'b1;
        in_data  = 24'(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic write_code(logic [7:0] b);
        code_we    = 1'b1;
        code_wdata = b;
        @(negedge clk);
        code_we = 1'b0;
        if (!b[7]) m_code = int'(b[6:0]);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle(string tag);
        while (m_gain != tgain(m_code)) send(8031, tag);
    endtask

    // Monitor: compare each result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.cyc, "R7 latency", cyc, e.cyc);
                check($signed(out_data) == e.data, e.tag, $signed(out_data), e.data);
            end
        end
    end

    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int probes[8];
        int rnd_vals[8];
        probes   = '{8'h01, 8'h0F, 8'h10, 8'h23, 8'h5A, 8'h7E, 8'h40, 8'h00};
        rnd_vals = '{-7, -1, 1, 3, 12345, -12345, 8388607, -8388608};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(out_data == '0, "R1 out_data after reset", out_data, 0);
        for (int i = 0; i < 4; i++) send(1000 + i, "R1 muted before write");

        // R4: full ramp up; a sample of 8031 returns the gain in use
        write_code(8'h7F);
        settle("R4 ramp up");
        for (int i = 0; i < 5; i++) send(8031, "R4 stop at target");

        // R8: unity passes extremes unchanged
        send(8388607, "R8 max positive");
        send(-8388608, "R8 max negative");
        send(-1, "R8 minus one");
        send(1, "R8 plus one");

        // R4: idle gaps do not move the gain
        write_code(8'h00);
        for (int i = 0; i < 10; i++) send(8031, "R4 ramp down");
        idle(20);
        send(8031, "R4 no move while idle");
        idle(7);
        send(8031, "R4 no move while idle");

        // R5: retarget mid-ramp in both directions
        write_code(8'h30);
        for (int i = 0; i < 300; i++) send(8031, "R5 before retarget");
        write_code(8'h7F);
        for (int i = 0; i < 150; i++) send(8031, "R5 after retarget up");
        write_code(8'h10);
        for (int i = 0; i < 150; i++) send(8031, "R5 after retarget down");
        settle("R5 settle");

        // R2: bit-7 write is dropped; output unchanged afterwards
        write_code(8'h85);
        for (int i = 0; i < 20; i++) send(8031, "R2 high-bit write ignored");
        write_code(8'hFF);
        for (int i = 0; i < 20; i++) send(-4000, "R2 high-bit write ignored");

        // R3: probe points on the curve after settling
        foreach (probes[k]) begin
            write_code(8'(probes[k]));
            settle("R3 settle");
            send(8031, "R3 mapped gain");
        end

        // R6: rounding and sign handling at a mid gain
        write_code(8'h40);
        settle("R6 settle");
        foreach (rnd_vals[k]) send(rnd_vals[k], "R6 rounding");
        write_code(8'h21);
        settle("R6 settle");
        foreach (rnd_vals[k]) send(rnd_vals[k], "R6 rounding");

        idle(5);
        check(sb.size() == 0, "R7 results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule